// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block owns the refresh duty of an asynchronous DRAM that has its own internal row counter. Out of reset it holds every strobe inactive for a start-up delay, then runs a fixed number of initialization refresh cycles on its own, without asking anyone. Only after the last of those cycles has fully recovered does it raise `init_done`, which tells the access sequencer that normal traffic may begin.

From then on a free-running interval timer adds one unit of refresh debt per interval. While debt is outstanding and no refresh is in flight, the block raises `ref_req`. The access sequencer answers with `ref_grant` once the memory is free, and the block then drives a CAS-before-RAS refresh cycle directly on the strobes: a short lead with both strobes high, CAS low alone, both low for the RAS pulse, then a precharge with both high. No address is driven. Write enable stays high throughout so that the memory's test mode can never be entered. If grants are delayed, debt accumulates up to a cap and is paid off in a back-to-back burst. All timings are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high, and in the cycle it is released, `ras_n`, `cas_n` and `we_n` are 1 and `ref_req`, `refresh_busy` and `init_done` are 0.
- R2: For the first STARTUP_CYC cycles after reset release, `cas_n` and `ras_n` stay 1 and `refresh_busy` stays 0.
- R3: After the start-up delay exactly INIT_REFS refresh cycles run back to back, separated by one idle cycle, without any grant; `init_done` rises one cycle after `refresh_busy` falls at the end of the last one and then stays 1 until reset.
- R4: Each refresh cycle (strobes active low) is LEAD_CYC cycles with both strobes 1, then SETUP_CYC cycles with `cas_n`=0 and `ras_n`=1, then STROBE_CYC cycles with both 0, then RECOVER_CYC cycles with both 1; CAS never falls while RAS is low.
- R5: `we_n` is 1 in every cycle.
- R6: Once `init_done` is 1, one unit of debt is added every INTERVAL_CYC cycles, counted from the first cycle with `init_done` high; `ref_req` is 1 exactly when `init_done` is 1, no refresh is in flight and debt is nonzero. With `ref_grant` held at 1 in steady state, refresh cycles start exactly INTERVAL_CYC cycles apart.
- R7: `ref_grant`=1 in a cycle with `ref_req`=1 starts a refresh cycle at the next clock edge (LEAD phase, `refresh_busy`=1) and consumes one unit of debt; `ref_grant` in a cycle with `ref_req`=0 has no effect.
- R8: Debt saturates at MAX_DEBT; intervals expiring at the cap are dropped. With grant held, outstanding debt is served as back-to-back refresh cycles with one idle cycle between them.
- R9: `refresh_busy` is 1 exactly during the four phases of a refresh cycle and 0 otherwise.
- R10: Before `init_done`, `ref_req` stays 0 and `ref_grant` does not add, remove or shift any refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Access sequencer allows a refresh cycle to start |
| ref_req | output | 1 | Refresh debt outstanding and engine idle |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| init_done | output | 1 | Start-up delay and initialization refreshes complete |
| refresh_busy | output | 1 | A refresh cycle is in flight |

## Verification
The bench holds the grant high through the start-up wait and initialization, so a design that let a grant start an extra refresh or raise a request before initialization ends would show a ninth strobe pulse or an early request. It withholds the grant long enough to overflow the debt cap and then releases it right after an interval boundary: a design without saturation would burst more than MAX_DEBT cycles, and one that forgot to decrement would never drop the request. A stray grant while no debt is pending catches an engine that starts on grant alone, and the steady-state spacing check catches a timer that reloads on service instead of free-running, which would stretch the refresh period by the service latency.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER
    } phase_t;

    typedef enum logic [1:0] {
        MD_POWERUP,
        MD_INIT,
        MD_RUN
    } mode_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic phase_t phase_after(phase_t p);
        case (p)
            PH_LEAD:   return PH_SETUP;
            PH_SETUP:  return PH_STROBE;
            PH_STROBE: return PH_RECOVER;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic int phase_len(phase_t p, int lead, int setup, int strobe, int recover);
        case (p)
            PH_LEAD:    return lead;
            PH_SETUP:   return setup;
            PH_STROBE:  return strobe;
            PH_RECOVER: return recover;
            default:    return 1;
        endcase
    endfunction

    function automatic strobe_t strobe_decode(phase_t p);
        strobe_t s;
        s.we_n  = 1'b1;
        s.ras_n = (p != PH_STROBE);
        s.cas_n = !((p == PH_SETUP) || (p == PH_STROBE));
        return s;
    endfunction

endpackage

// File: rtl/refresh_cycle_engine.sv
module refresh_cycle_engine
    import dram_refresh_pkg::*;
#(
    parameter int LEAD_CYC    = 1,
    parameter int SETUP_CYC   = 1,
    parameter int STROBE_CYC  = 9,
    parameter int RECOVER_CYC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int MAX_LEN = (LEAD_CYC > SETUP_CYC ? LEAD_CYC : SETUP_CYC) >
                             (STROBE_CYC > RECOVER_CYC ? STROBE_CYC : RECOVER_CYC) ?
                             (LEAD_CYC > SETUP_CYC ? LEAD_CYC : SETUP_CYC) :
                             (STROBE_CYC > RECOVER_CYC ? STROBE_CYC : RECOVER_CYC);
    localparam int CW = $clog2(MAX_LEN + 1);

    phase_t        phase;
    phase_t        nxt;
    logic [CW-1:0] cnt;
    strobe_t       pins;

    assign nxt = phase_after(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= PH_LEAD;
                cnt   <= CW'(LEAD_CYC - 1);
            end
        end else if (cnt == '0) begin
            phase <= nxt;
            cnt   <= CW'(phase_len(nxt, LEAD_CYC, SETUP_CYC, STROBE_CYC, RECOVER_CYC) - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pins  = strobe_decode(phase);
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign busy  = (phase != PH_IDLE);

    // R4: column strobe must already be low, and low in the cycle before, when RAS falls
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R4: column strobe only falls while RAS is still high
    a_r4_cas_falls_ras_high: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ras_n);

    // R4: CAS is released together with RAS, never before
    a_r4_release_together: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> $rose(ras_n));

    // R9: strobes stay idle whenever no refresh cycle is in flight
    a_r9_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n));

endmodule

// File: rtl/refresh_init_ctrl.sv
module refresh_init_ctrl
    import dram_refresh_pkg::*;
#(
    parameter int STARTUP_CYC = 25000,
    parameter int INIT_REFS   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic init_start,
    output logic init_done
);
    localparam int WCW = $clog2(STARTUP_CYC + 1);
    localparam int LCW = $clog2(INIT_REFS + 1);

    mode_t          mode;
    logic [WCW-1:0] wait_cnt;
    logic [LCW-1:0] left;

    assign init_start = (mode == MD_INIT) && !busy && (left != '0);
    assign init_done  = (mode == MD_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MD_POWERUP;
            wait_cnt <= '0;
            left     <= LCW'(INIT_REFS);
        end else begin
            case (mode)
                MD_POWERUP: begin
                    if (wait_cnt == WCW'(STARTUP_CYC - 1)) mode <= MD_INIT;
                    else                                   wait_cnt <= wait_cnt + 1'b1;
                end
                MD_INIT: begin
                    if (init_start)                     left <= left - 1'b1;
                    else if (!busy && left == '0)       mode <= MD_RUN;
                end
                default: mode <= MD_RUN;
            endcase
        end
    end

    // R2: no refresh activity while the start-up delay runs
    a_r2_quiet_powerup: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_POWERUP) |-> !busy);

    // R3: once released, the memory stays released until reset
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R3: release never happens with a refresh still in flight
    a_r3_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> !busy);

endmodule

// File: rtl/refresh_debt_tracker.sv
module refresh_debt_tracker #(
    parameter int INTERVAL_CYC = 1950,
    parameter int MAX_DEBT     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic take,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);
    localparam int DW = $clog2(MAX_DEBT + 1);

    logic [TW-1:0] timer;
    logic [DW-1:0] debt;
    logic          expire;

    assign expire  = (timer == TW'(INTERVAL_CYC - 1));
    assign pending = (debt != '0);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            timer <= '0;
            debt  <= '0;
        end else begin
            timer <= expire ? '0 : timer + 1'b1;
            if (expire && !take) begin
                if (debt != DW'(MAX_DEBT)) debt <= debt + 1'b1;
            end else if (!expire && take) begin
                debt <= debt - 1'b1;
            end
        end
    end

    // R8: the debt never climbs past its cap
    a_r8_debt_cap: assert property (@(posedge clk) disable iff (rst)
        debt <= DW'(MAX_DEBT));

    // R7: service is only taken against outstanding debt
    a_r7_take_has_debt: assert property (@(posedge clk) disable iff (rst)
        take |-> pending);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int STARTUP_CYC  = 25000,
    parameter int INIT_REFS    = 8,
    parameter int INTERVAL_CYC = 1950,
    parameter int MAX_DEBT     = 8,
    parameter int LEAD_CYC     = 1,
    parameter int SETUP_CYC    = 1,
    parameter int STROBE_CYC   = 9,
    parameter int RECOVER_CYC  = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_grant,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic refresh_busy
);
    logic init_start;
    logic pending;
    logic take;
    logic start;

    assign ref_req = init_done && !refresh_busy && pending;
    assign take    = ref_req && ref_grant;
    assign start   = init_start || take;

    refresh_init_ctrl #(
        .STARTUP_CYC (STARTUP_CYC),
        .INIT_REFS   (INIT_REFS)
    ) u_init (
        .clk        (clk),
        .rst        (rst),
        .busy       (refresh_busy),
        .init_start (init_start),
        .init_done  (init_done)
    );

    refresh_debt_tracker #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_DEBT     (MAX_DEBT)
    ) u_debt (
        .clk     (clk),
        .rst     (rst),
        .enable  (init_done),
        .take    (take),
        .pending (pending)
    );

    refresh_cycle_engine #(
        .LEAD_CYC    (LEAD_CYC),
        .SETUP_CYC   (SETUP_CYC),
        .STROBE_CYC  (STROBE_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_engine (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (refresh_busy),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    // R7: an honoured grant puts a cycle in flight at the next edge
    a_r7_grant_starts: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_grant) |=> (refresh_busy && ras_n && cas_n));

    // R10: no initialization refresh overlaps with a request window
    a_r10_init_no_req: assert property (@(posedge clk) disable iff (rst)
        init_start |-> !ref_req);

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int STARTUP  = 20;
    localparam int NINIT    = 8;
    localparam int INTERVAL = 40;
    localparam int MAXD     = 3;
    localparam int T_LEAD   = 1;
    localparam int T_SETUP  = 1;
    localparam int T_STROBE = 4;
    localparam int T_REC    = 3;
    localparam int LEN      = T_LEAD + T_SETUP + T_STROBE + T_REC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_grant = 1'b0;
    logic ref_req, ras_n, cas_n, we_n, init_done, refresh_busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .STARTUP_CYC (STARTUP), .INIT_REFS (NINIT), .INTERVAL_CYC (INTERVAL),
        .MAX_DEBT (MAXD), .LEAD_CYC (T_LEAD), .SETUP_CYC (T_SETUP),
        .STROBE_CYC (T_STROBE), .RECOVER_CYC (T_REC)
    ) uut (
        .clk (clk), .rst (rst), .ref_grant (ref_grant), .ref_req (ref_req),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .init_done (init_done),
        .refresh_busy (refresh_busy)
    );

    // behavioural reference: 0 powerup, 1 init, 2 run; pos -1 means idle
    int m_mode, m_wait, m_left, m_pos, m_timer, m_debt;
    int n_debt;
    bit m_req, m_start, m_exp, m_take;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_wait = 0; m_left = NINIT; m_pos = -1; m_timer = 0; m_debt = 0;
        end else begin
            m_req   = (m_mode == 2) && (m_pos < 0) && (m_debt > 0);
            m_take  = m_req && ref_grant;
            m_start = m_take || ((m_mode == 1) && (m_pos < 0) && (m_left > 0));
            m_exp   = (m_mode == 2) && (m_timer == INTERVAL - 1);
            n_debt  = m_debt + int'(m_exp) - int'(m_take);
            if (n_debt > MAXD) n_debt = MAXD;
            if (m_mode == 0) begin
                if (m_wait == STARTUP - 1) m_mode = 1; else m_wait++;
            end else if (m_mode == 1) begin
                if (m_pos < 0 && m_left > 0) m_left--;
                else if (m_pos < 0) m_mode = 2;
            end else begin
                m_timer = m_exp ? 0 : m_timer + 1;
                m_debt  = n_debt;
            end
            if (m_start) m_pos = 0;
            else if (m_pos >= 0) m_pos = (m_pos == LEN - 1) ? -1 : m_pos + 1;
        end
    end

    function automatic bit exp_ras(int p);
        return !(p >= T_LEAD + T_SETUP && p < T_LEAD + T_SETUP + T_STROBE);
    endfunction
    function automatic bit exp_cas(int p);
        return !(p >= T_LEAD && p < LEN - T_REC);
    endfunction

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        check("R4", "ras_n", ras_n, exp_ras(m_pos));
        check("R4", "cas_n", cas_n, exp_cas(m_pos));
        check("R5", "we_n", we_n, 1);
        check("R6", "ref_req", ref_req, (m_mode == 2) && (m_pos < 0) && (m_debt > 0));
        check("R9", "refresh_busy", refresh_busy, m_pos >= 0);
        check("R3", "init_done", init_done, m_mode == 2);
    end

    int ras_falls;
    bit prev_ras, prev_busy, saw_req;
    int rises;
    int rise_t[$];
    int cyc;

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ref_grant = 1'b1;   // R10: grant held high from reset through init
        repeat (4) @(negedge clk);
        check("R1", "reset ras_n", ras_n, 1);
        check("R1", "reset cas_n", cas_n, 1);
        check("R1", "reset we_n", we_n, 1);
        check("R1", "reset ref_req", ref_req, 0);
        check("R1", "reset busy", refresh_busy, 0);
        check("R1", "reset init_done", init_done, 0);
        rst = 1'b0;

        // R2: quiet start-up window
        saw_req = 0;
        for (int i = 0; i < STARTUP; i++) begin
            @(negedge clk);
            if (!cas_n || !ras_n || refresh_busy) saw_req = 1;
        end
        check("R2", "strobe activity during start-up", saw_req, 0);

        // R3, R10: exactly NINIT refreshes before release, no request
        ras_falls = 0; saw_req = 0; prev_ras = ras_n;
        for (int i = 0; i < 200 && !init_done; i++) begin
            @(negedge clk);
            if (prev_ras && !ras_n) ras_falls++;
            if (ref_req) saw_req = 1;
            prev_ras = ras_n;
        end
        check("R3", "init refresh count", ras_falls, NINIT);
        check("R3", "init_done reached", init_done, 1);
        check("R10", "ref_req before init_done", saw_req, 0);
        ref_grant = 1'b0;

        // R7: stray grant with no debt is ignored
        repeat (5) @(negedge clk);
        check("R7", "ref_req before stray grant", ref_req, 0);
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
        check("R7", "busy after stray grant", refresh_busy, 0);
        check("R7", "ras_n after stray grant", ras_n, 1);

        // R8: overflow the debt cap, then burst right after an interval boundary
        repeat (260) @(negedge clk);
        check("R6", "ref_req with debt pending", ref_req, 1);
        while (m_timer != 0) @(negedge clk);
        ref_grant = 1'b1;
        rises = 0; prev_busy = refresh_busy;
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            if (refresh_busy && !prev_busy) rises++;
            prev_busy = refresh_busy;
        end
        check("R8", "burst length at cap", rises, MAXD);
        check("R8", "ref_req after burst", ref_req, 0);

        // R6: steady-state spacing with grant held
        cyc = 0; prev_busy = refresh_busy;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cyc++;
            if (refresh_busy && !prev_busy) rise_t.push_back(cyc);
            prev_busy = refresh_busy;
        end
        check("R6", "enough steady refreshes", rise_t.size() >= 8, 1);
        for (int k = 1; k < rise_t.size(); k++)
            check("R6", "refresh spacing", rise_t[k] - rise_t[k-1], INTERVAL);

        // R7: sparse grant pulses, reference comparison runs throughout
        for (int i = 0; i < 600; i++) begin
            ref_grant = (i % 7 == 0);
            @(negedge clk);
        end
        ref_grant = 1'b0;
        repeat (20) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule